// File: doc/BRIEF.md
# Serial Camera Lane Remapper

The block sits between the per-lane byte deserialisers of a multi-lane serial camera link and the stage that merges lane bytes back into packets. The board can route the lanes to any physical pins, and any lane can be wired inverted. The remapper takes byte streams from every physical lane slot. It steers the selected slots onto logical lanes 0, 1, 2 and so on. It complements the bytes of each lane marked as inverted. All of this is done in one register stage.

Configuration arrives on static inputs. The first input is a table giving the physical slot for each logical data lane. The second gives the physical slot that carries the clock lane, which shares the same index space as the data lanes. The others are a polarity table, a flag that says whether that polarity table is present, and the number of active logical lanes. A configuration that maps two active logical lanes to one physical slot is rejected. So is one that maps a data lane onto the clock slot, uses an index past the last slot, or gives an out-of-range lane count. A rejected configuration raises an error flag and holds every output idle.

Top module: `lane_remap`

## Requirements
- R1: After reset, and until the first clock edge that follows it, every bit of `logValid` and `logData` is 0.
- R2: The data-lane table packs one index field per logical lane. Logical lane i uses bits [3*i+2 : 3*i]. When the configuration is accepted, logical lane i carries the byte and valid of the physical slot named in field i. Physical slot p uses bits [8*p+7 : 8*p] of `phyData` and bit p of `phyValid`.
- R3: The table order sets the routing even when the physical order is reversed. For example, with fields {2, 1} and a lane count of 2, physical slot 2 drives logical lane 0 and physical slot 1 drives logical lane 1.
- R4: In `cfgPolarity`, bit 0 belongs to the clock lane and bit i+1 belongs to logical data lane i. A value of 1 means inverted. With `cfgPolValid` = 1, an inverted data lane's output byte is the bitwise complement of its physical byte. `clkLaneInv` then equals bit 0.
- R5: With `cfgPolValid` = 0, the polarity bits have no effect. Every data byte passes through unchanged and `clkLaneInv` is 0.
- R6: `cfgError` is 1, combinationally, in any of these cases: the lane count is 0 or greater than 4; the clock index is greater than 4; any active data field is greater than 4, equals the clock index, or repeats an earlier active field. While it is 1, every `logValid` bit and `logData` byte is 0 one cycle later.
- R7: Logical lanes at or above the lane count drive valid 0 and data 0. Their table fields are not checked, so duplicates there raise no error.
- R8: An output follows its input by exactly one clock edge. The valid and data of a lane come from the same input cycle. A one-cycle valid pulse on the input gives a one-cycle valid pulse on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Asynchronous reset, active low |
| phyData | input | 40 | Bytes from the 5 physical lane slots, slot p at [8p+7:8p] |
| phyValid | input | 5 | Byte valid per physical slot |
| cfgClkLane | input | 3 | Physical slot of the clock lane |
| cfgDataLane | input | 12 | Physical slot per logical lane, field i at [3i+2:3i] |
| cfgPolValid | input | 1 | Polarity table present |
| cfgPolarity | input | 5 | Bit 0 clock lane, bit i+1 logical lane i; 1 = inverted |
| cfgLaneCount | input | 3 | Number of active logical lanes, 1 to 4 |
| logData | output | 32 | Bytes in logical order, lane i at [8i+7:8i] |
| logValid | output | 4 | Valid per logical lane |
| cfgError | output | 1 | Configuration rejected |
| clkLaneInv | output | 1 | Effective inversion of the clock lane |

## Verification
The bench builds the block with its default parameters: four logical lanes, five physical slots and 8-bit bytes. With these values the clock lane can sit in the first slot, the last slot or a middle slot. Full four-lane permutations, reversed two-lane maps and every class of rejected table all fit in a small set of directed patterns. The byte values are chosen so that a wrong slot, a missing complement or a stale cycle each give a different output.

// File: rtl/lane_remap_pkg.sv
package lane_remap_pkg;

  // Logical data lanes and physical slots (data lanes plus one clock lane).
  parameter int unsigned LANES     = 4;
  parameter int unsigned PHY_LANES = LANES + 1;
  parameter int unsigned IDX_W     = $clog2(PHY_LANES);
  parameter int unsigned CNT_W     = $clog2(LANES + 1);

  // Strobes from the configuration checker to the datapath.
  typedef struct packed {
    logic [LANES-1:0]            laneEn;
    logic [LANES-1:0]            laneInv;
    logic [LANES-1:0][IDX_W-1:0] laneSel;
  } remap_ctrl_t;

endpackage

// File: rtl/lane_remap_ctrl.sv
module lane_remap_ctrl
  import lane_remap_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [IDX_W-1:0]       cfgClkLane,
  input  logic [LANES*IDX_W-1:0] cfgDataLane,
  input  logic                   cfgPolValid,
  input  logic [LANES:0]         cfgPolarity,
  input  logic [CNT_W-1:0]       cfgLaneCount,
  output remap_ctrl_t            ctrl,
  output logic                   cfgError
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PHY_LANES - 1);
  localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(LANES);

  logic [IDX_W-1:0] fieldSel [LANES];
  logic [LANES-1:0] laneActive;
  logic             anyBad;

  // Split the packed table and mark which logical lanes are in use.
  for (genvar gi = 0; gi < LANES; gi++) begin : g_field
    assign fieldSel[gi]   = cfgDataLane[gi*IDX_W +: IDX_W];
    assign laneActive[gi] = (CNT_W'(gi) < cfgLaneCount);
  end

  // Table consistency: range, clock collision, duplicate among active lanes.
  always_comb begin
    anyBad = (cfgLaneCount == '0) || (cfgLaneCount > MAX_CNT) ||
             (cfgClkLane > LAST_IDX);
    for (int i = 0; i < LANES; i++) begin
      if (laneActive[i]) begin
        if (fieldSel[i] > LAST_IDX)    anyBad = 1'b1;
        if (fieldSel[i] == cfgClkLane) anyBad = 1'b1;
        for (int j = 0; j < i; j++) begin
          if (fieldSel[j] == fieldSel[i]) anyBad = 1'b1;
        end
      end
    end
  end

  assign cfgError = anyBad;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_strobe
    assign ctrl.laneEn[gi]  = laneActive[gi] & ~anyBad;
    assign ctrl.laneInv[gi] = cfgPolValid & cfgPolarity[gi+1];
    assign ctrl.laneSel[gi] = fieldSel[gi];
  end

  // Enabled lanes never share a slot and never take the clock slot.
  for (genvar ga = 0; ga < LANES; ga++) begin : g_chk_a
    p_clk_apart_r6: assert property (@(posedge clk) disable iff (!rstN)
      ctrl.laneEn[ga] |-> (ctrl.laneSel[ga] != cfgClkLane));
    for (genvar gb = ga + 1; gb < LANES; gb++) begin : g_chk_b
      p_distinct_r6: assert property (@(posedge clk) disable iff (!rstN)
        (ctrl.laneEn[ga] && ctrl.laneEn[gb]) |->
          (ctrl.laneSel[ga] != ctrl.laneSel[gb]));
    end
  end

endmodule

// File: rtl/lane_remap_dp.sv
module lane_remap_dp
  import lane_remap_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [PHY_LANES*BYTE_W-1:0] phyData,
  input  logic [PHY_LANES-1:0]      phyValid,
  input  remap_ctrl_t               ctrl,
  output logic [LANES*BYTE_W-1:0]   logData,
  output logic [LANES-1:0]          logValid
);

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    logic [BYTE_W-1:0] pickData;
    logic              pickValid;

    always_comb begin
      pickData  = '0;
      pickValid = 1'b0;
      for (int p = 0; p < PHY_LANES; p++) begin
        if (ctrl.laneSel[gi] == IDX_W'(p)) begin
          pickData  = phyData[p*BYTE_W +: BYTE_W];
          pickValid = phyValid[p];
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        logData[gi*BYTE_W +: BYTE_W] <= '0;
        logValid[gi]                 <= 1'b0;
      end else if (ctrl.laneEn[gi]) begin
        logData[gi*BYTE_W +: BYTE_W] <= pickData ^ {BYTE_W{ctrl.laneInv[gi]}};
        logValid[gi]                 <= pickValid;
      end else begin
        logData[gi*BYTE_W +: BYTE_W] <= '0;
        logValid[gi]                 <= 1'b0;
      end
    end

    // Valid tracks the chosen slot one edge later.
    p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.laneEn[gi] && phyValid[ctrl.laneSel[gi]]) |=> logValid[gi]);
    p_valid_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.laneEn[gi] && !phyValid[ctrl.laneSel[gi]]) |=> !logValid[gi]);
  end

endmodule

// File: rtl/lane_remap.sv
module lane_remap
  import lane_remap_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [PHY_LANES*BYTE_W-1:0] phyData,
  input  logic [PHY_LANES-1:0]        phyValid,
  input  logic [IDX_W-1:0]            cfgClkLane,
  input  logic [LANES*IDX_W-1:0]      cfgDataLane,
  input  logic                        cfgPolValid,
  input  logic [LANES:0]              cfgPolarity,
  input  logic [CNT_W-1:0]            cfgLaneCount,
  output logic [LANES*BYTE_W-1:0]     logData,
  output logic [LANES-1:0]            logValid,
  output logic                        cfgError,
  output logic                        clkLaneInv
);

  remap_ctrl_t ctrl;

  lane_remap_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgClkLane   (cfgClkLane),
    .cfgDataLane  (cfgDataLane),
    .cfgPolValid  (cfgPolValid),
    .cfgPolarity  (cfgPolarity),
    .cfgLaneCount (cfgLaneCount),
    .ctrl         (ctrl),
    .cfgError     (cfgError)
  );

  lane_remap_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .phyData  (phyData),
    .phyValid (phyValid),
    .ctrl     (ctrl),
    .logData  (logData),
    .logValid (logValid)
  );

  assign clkLaneInv = cfgPolValid & cfgPolarity[0];

  p_err_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> (logValid == '0) && (logData == '0));

  for (genvar gi = 0; gi < LANES; gi++) begin : g_unused
    p_unused_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
      (CNT_W'(gi) >= cfgLaneCount) |=> !logValid[gi]);
  end

endmodule

// File: tb/lane_remap_bench.sv
module lane_remap_bench;

  localparam int NL = 4;
  localparam int NP = 5;
  localparam int BW = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NP*BW-1:0] phyData = '0;
  logic [NP-1:0]  phyValid = '0;
  logic [2:0]     cfgClkLane = '0;
  logic [NL*3-1:0] cfgDataLane = '0;
  logic           cfgPolValid = 1'b0;
  logic [NL:0]    cfgPolarity = '0;
  logic [2:0]     cfgLaneCount = 3'd1;
  logic [NL*BW-1:0] logData;
  logic [NL-1:0]  logValid;
  logic           cfgError;
  logic           clkLaneInv;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lane_remap u_lane_remap (
    .clk(clk), .rstN(rstN), .phyData(phyData), .phyValid(phyValid),
    .cfgClkLane(cfgClkLane), .cfgDataLane(cfgDataLane),
    .cfgPolValid(cfgPolValid), .cfgPolarity(cfgPolarity),
    .cfgLaneCount(cfgLaneCount), .logData(logData), .logValid(logValid),
    .cfgError(cfgError), .clkLaneInv(clkLaneInv)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic setCfg(logic [2:0] clkIdx, logic [2:0] f0, logic [2:0] f1,
                        logic [2:0] f2, logic [2:0] f3, logic [2:0] cnt,
                        logic pv, logic [4:0] pol);
    cfgClkLane   = clkIdx;
    cfgDataLane  = {f3, f2, f1, f0};
    cfgLaneCount = cnt;
    cfgPolValid  = pv;
    cfgPolarity  = pol;
  endtask

  // Drive one byte cycle at a falling edge, let one rising edge pass, sample after it.
  task automatic cycle(logic [NP*BW-1:0] d, logic [NP-1:0] v);
    @(negedge clk);
    phyData  = d;
    phyValid = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Expected output of logical lane i when fed by slot s (R2/R4/R5).
  function automatic logic [7:0] slotByte(logic [NP*BW-1:0] d, int s, logic inv);
    return d[s*BW +: BW] ^ {8{inv}};
  endfunction

  localparam logic [NP*BW-1:0] PAT_A = {8'h44, 8'h33, 8'h22, 8'h11, 8'h0C};
  localparam logic [NP*BW-1:0] PAT_B = {8'hD4, 8'hC3, 8'hB2, 8'hA1, 8'h90};

  task automatic t_reset();
    check("R1", "logValid after reset", 32'(logValid), 32'h0);
    check("R1", "logData after reset", logData, 32'h0);
  endtask

  task automatic t_identity();
    setCfg(3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd4, 1'b0, 5'b0);
    cycle(PAT_A, 5'b11110);
    check("R6", "cfgError identity", 32'(cfgError), 32'h0);
    check("R2", "logValid identity", 32'(logValid), 32'hF);
    check("R2", "logData identity", logData, 32'h44332211);
  endtask

  task automatic t_permute();
    setCfg(3'd4, 3'd3, 3'd0, 3'd2, 3'd1, 3'd4, 1'b0, 5'b0);
    cycle(PAT_B, 5'b01111);
    check("R2", "logData permuted", logData,
          {slotByte(PAT_B, 1, 0), slotByte(PAT_B, 2, 0),
           slotByte(PAT_B, 0, 0), slotByte(PAT_B, 3, 0)});
    check("R2", "logValid permuted", 32'(logValid), 32'hF);
  endtask

  task automatic t_swap_two();
    // Fields 2 and 3 duplicate each other but are unused (R7).
    setCfg(3'd0, 3'd2, 3'd1, 3'd1, 3'd1, 3'd2, 1'b0, 5'b0);
    cycle(PAT_A, 5'b00110);
    check("R7", "no error on unused duplicates", 32'(cfgError), 32'h0);
    check("R3", "logical lane 0 from slot 2", 32'(logData[7:0]), 32'h22);
    check("R3", "logical lane 1 from slot 1", 32'(logData[15:8]), 32'h11);
    check("R7", "unused lanes valid", 32'(logValid), 32'h3);
    check("R7", "unused lanes data", 32'(logData[31:16]), 32'h0);
  endtask

  task automatic t_polarity();
    setCfg(3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd4, 1'b1, 5'b10101);
    cycle(PAT_A, 5'b11110);
    check("R4", "clkLaneInv with table", 32'(clkLaneInv), 32'h1);
    check("R4", "lane data with inversion", logData,
          {~8'h44, 8'h33, ~8'h22, 8'h11});
  endtask

  task automatic t_no_polarity();
    setCfg(3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd4, 1'b0, 5'b11111);
    cycle(PAT_A, 5'b11110);
    check("R5", "clkLaneInv without table", 32'(clkLaneInv), 32'h0);
    check("R5", "data untouched without table", logData, 32'h44332211);
  endtask

  task automatic t_errors();
    setCfg(3'd0, 3'd1, 3'd1, 3'd3, 3'd4, 3'd2, 1'b0, 5'b0);
    cycle(PAT_A, 5'b11111);
    check("R6", "duplicate flagged", 32'(cfgError), 32'h1);
    check("R6", "duplicate idle valid", 32'(logValid), 32'h0);
    check("R6", "duplicate idle data", logData, 32'h0);
    setCfg(3'd2, 3'd2, 3'd1, 3'd3, 3'd4, 3'd1, 1'b0, 5'b0);
    cycle(PAT_A, 5'b11111);
    check("R6", "clock slot reuse flagged", 32'(cfgError), 32'h1);
    check("R6", "clock reuse idle", 32'(logValid), 32'h0);
    setCfg(3'd0, 3'd5, 3'd1, 3'd2, 3'd3, 3'd1, 1'b0, 5'b0);
    cycle(PAT_A, 5'b11111);
    check("R6", "index out of range flagged", 32'(cfgError), 32'h1);
    setCfg(3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd0, 1'b0, 5'b0);
    cycle(PAT_A, 5'b11111);
    check("R6", "zero count flagged", 32'(cfgError), 32'h1);
    setCfg(3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 1'b0, 5'b0);
    cycle(PAT_A, 5'b11111);
    check("R6", "count above max flagged", 32'(cfgError), 32'h1);
    check("R6", "count above max idle", 32'(logValid), 32'h0);
  endtask

  task automatic t_latency();
    setCfg(3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd4, 1'b0, 5'b0);
    cycle(PAT_B, 5'b00000);
    @(negedge clk);
    phyData  = PAT_A;
    phyValid = 5'b11110;
    #1;
    check("R8", "no change before edge", 32'(logValid), 32'h0);
    @(posedge clk);
    @(negedge clk);
    phyData  = PAT_B;
    phyValid = 5'b00000;
    #1;
    check("R8", "pulse data after one edge", logData, 32'h44332211);
    check("R8", "pulse valid after one edge", 32'(logValid), 32'hF);
    @(posedge clk);
    @(negedge clk);
    check("R8", "pulse ends after one cycle", 32'(logValid), 32'h0);
    check("R8", "data follows next cycle", logData, 32'hD4C3B2A1);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_identity();
    t_permute();
    t_swap_two();
    t_polarity();
    t_no_polarity();
    t_errors();
    t_latency();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule